// File: doc/BRIEF.md
# Weighted Fixed-Slot Shared-Port Arbiter

This block decides, every clock, which of sixteen cores owns a single shared memory port. Access is handed out on a repeating 64-clock frame. The cores do not all get the same rate. They are grouped into five tiers, and each tier's period is a power of two: 4, 8, 16, 32 or 64 clocks. One core is in the fastest tier, two are in the next, five are in the middle tier, and four are in each of the two slowest tiers. The shares add up to exactly one owner per clock, so no slot in the frame is left empty.

Ownership is a pure function of a free-running slot counter. Because of this, the wait a core sees between two accesses is fixed and known in advance. The arbiter has no request inputs. The owner's grant is raised whether or not that core wants the port, and an unused slot is never passed to another core. An enable input pauses the frame: while it is low, the counter holds its value and no grant is raised. When it returns high, the frame continues from the slot where it stopped.

Top module: `hub_slot_arbiter`

## Requirements
- R1: While reset is high, and after reset is released, the slot counter is 0. The first owner is therefore core 0, and its grant bit is high as long as the enable is high.
- R2: In every clock with the enable high, exactly one bit of `grant` is set. That bit is the one indexed by `owner`. The slot counter then moves forward by one, wrapping from 63 to 0.
- R3: In a clock with the enable low, `grant` is all zero and the slot counter does not change. When the enable returns, the schedule resumes at the held slot.
- R4: Core 0 owns every slot s where s mod 4 equals 0.
- R5: Core 1 owns the slots with s mod 8 = 2. Core 2 owns the slots with s mod 8 = 6.
- R6: Cores 3 to 7 each own one odd slot per 16. Core 3+j owns the slots with s mod 16 = 2j+1, for j = 0..4.
- R7: Cores 8, 9, 10 and 11 own the slots with s mod 32 equal to 11, 13, 15 and 27 respectively.
- R8: Cores 12, 13, 14 and 15 own the single slots 29, 31, 61 and 63 of each frame, respectively.
- R9: Over any 64 enabled clocks, the number of grants is 16 for core 0, 8 for each of cores 1 and 2, 4 for each of cores 3 to 7, 2 for each of cores 8 to 11, and 1 for each of cores 12 to 15.
- R10: When counted in enabled clocks, every core's grants are strictly periodic. The gap between two successive grants is always that core's period, with no jitter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | High lets the frame advance and the grant be driven |
| owner | output | 4 | Index of the core that owns the current slot |
| grant | output | 16 | One-hot grant to the slot owner, all zero when disabled |

## Verification
Two events can land on the same clock: the enable drops or rises, and the slot counter wraps from 63 to 0. If the enable drops on the wrap slot, the frame must freeze on slot 63 with no grant, and it must resume at slot 63 rather than skipping to 0. The bench forces this case with directed enable pulses placed around slot 63. It also inserts random enable gaps throughout the run. A bench model that counts only enabled clocks judges the owner, the grant vector, the per-core counts in each window and the per-core gaps.

// File: rtl/hub_sched_pkg.sv
package hub_sched_pkg;
  localparam int NUM_CORES = 16;
  localparam int CORE_W    = $clog2(NUM_CORES);
  localparam int SLOT_W    = 6;
  localparam int FRAME_LEN = 1 << SLOT_W;

  // Tier boundaries (first core index of each tier)
  localparam int TIER1_BASE = 1;   // 1-in-8
  localparam int TIER2_BASE = 3;   // 1-in-16
  localparam int TIER3_BASE = 8;   // 1-in-32
  localparam int TIER4_BASE = 12;  // 1-in-64
  localparam int TIER2_CNT  = 5;

  // Owner of a slot. Even slots: the 1-in-4 core and the 1-in-8 pair.
  // Odd slots, indexed by k = s>>1: k mod 8 < 5 -> 1-in-16 tier,
  // k mod 16 in {5,6,7,13} -> 1-in-32 tier, k mod 16 in {14,15} -> 1-in-64.
  function automatic logic [CORE_W-1:0] owner_of_slot(input logic [SLOT_W-1:0] s);
    logic [SLOT_W-2:0] k;
    logic [CORE_W-1:0] r;
    k = s[SLOT_W-1:1];
    if (s[1:0] == 2'b00) begin
      r = '0;
    end else if (!s[0]) begin
      r = s[2] ? CORE_W'(TIER1_BASE + 1) : CORE_W'(TIER1_BASE);
    end else if (int'(k[2:0]) < TIER2_CNT) begin
      r = CORE_W'(TIER2_BASE + int'(k[2:0]));
    end else if (k[3:0] == 4'd13) begin
      r = CORE_W'(TIER3_BASE + 3);
    end else if (k[3:1] != 3'b111) begin
      r = CORE_W'(TIER3_BASE + int'(k[2:0]) - TIER2_CNT);
    end else begin
      r = CORE_W'(TIER4_BASE + int'({k[4], k[0]}));
    end
    return r;
  endfunction
endpackage

// File: rtl/hub_slot_counter.sv
module hub_slot_counter
  import hub_sched_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  output logic [SLOT_W-1:0] slot,
  output logic              frame_wrap
);
  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (rst)     slot_q <= '0;
    else if (en) slot_q <= slot_q + 1'b1;
  end

  assign slot       = slot_q;
  assign frame_wrap = en && (slot_q == SLOT_W'(FRAME_LEN - 1));

  p_freeze_r3: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(slot));
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    en |=> slot == SLOT_W'($past(slot) + 1'b1));
  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    frame_wrap |=> slot == '0);
endmodule

// File: rtl/hub_slot_decode.sv
module hub_slot_decode
  import hub_sched_pkg::*;
(
  input  logic [SLOT_W-1:0] slot,
  output logic [CORE_W-1:0] owner
);
  always_comb owner = owner_of_slot(slot);
endmodule

// File: rtl/hub_grant_drive.sv
module hub_grant_drive
  import hub_sched_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic [CORE_W-1:0]    owner,
  output logic [NUM_CORES-1:0] grant
);
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    assign grant[c] = en && (owner == CORE_W'(c));
  end

  p_single_r2: assert property (@(posedge clk) disable iff (rst)
    en |-> $countones(grant) == 1);
  p_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !en |-> grant == '0);
endmodule

// File: rtl/hub_slot_arbiter.sv
module hub_slot_arbiter
  import hub_sched_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  output logic [CORE_W-1:0]    owner,
  output logic [NUM_CORES-1:0] grant
);
  logic [SLOT_W-1:0] slot;
  logic              frame_wrap;

  hub_slot_counter u_cnt (
    .clk(clk), .rst(rst), .en(en), .slot(slot), .frame_wrap(frame_wrap)
  );

  hub_slot_decode u_dec (.slot(slot), .owner(owner));

  hub_grant_drive u_gnt (
    .clk(clk), .rst(rst), .en(en), .owner(owner), .grant(grant)
  );

  p_match_r2: assert property (@(posedge clk) disable iff (rst)
    en |-> grant[owner]);
  p_core0_gap_r4: assert property (@(posedge clk) disable iff (rst)
    grant[0] |=> !grant[0]);
  p_wrap_owner_r4: assert property (@(posedge clk) disable iff (rst)
    frame_wrap |=> owner == '0);
  p_last_slot_r8: assert property (@(posedge clk) disable iff (rst)
    frame_wrap |-> owner == CORE_W'(NUM_CORES - 1));
endmodule

// File: tb/hub_slot_arbiter_test.sv
module hub_slot_arbiter_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic        clk = 0;
  logic        rst = 1;
  logic        en  = 0;
  logic [3:0]  owner;
  logic [15:0] grant;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  int slot_m = 0;
  int en_steps = 0;
  int win_cnt [N];
  int last_hit [N];

  hub_slot_arbiter uut (.clk(clk), .rst(rst), .en(en), .owner(owner), .grant(grant));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int period_of(input int c);
    if (c == 0) return 4;
    if (c <= 2) return 8;
    if (c <= 7) return 16;
    if (c <= 11) return 32;
    return 64;
  endfunction

  function automatic int offset_of(input int c);
    case (c)
      0: return 0;   1: return 2;   2: return 6;
      3: return 1;   4: return 3;   5: return 5;   6: return 7;   7: return 9;
      8: return 11;  9: return 13;  10: return 15; 11: return 27;
      12: return 29; 13: return 31; 14: return 61; default: return 63;
    endcase
  endfunction

  function automatic int exp_owner(input int s);
    for (int c = 0; c < N; c++)
      if ((s % period_of(c)) == offset_of(c)) return c;
    return -1;
  endfunction

  function automatic string req_of(input int c);
    if (c == 0) return "R4";
    if (c <= 2) return "R5";
    if (c <= 7) return "R6";
    if (c <= 11) return "R7";
    return "R8";
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (slot %0d)", req, act, exp, slot_m);
    end
  endtask

  task automatic step(input bit en_v);
    int eo;
    en = en_v;
    @(posedge clk);
    @(negedge clk);
    // outputs now reflect slot after the edge; evaluate with en still applied
    if (en_v) begin
      slot_m = (slot_m + 1) % 64;
    end
    eo = exp_owner(slot_m);
    check(req_of(eo), int'(owner), eo);
    check(en_v ? "R2" : "R3", int'(grant), en_v ? (1 << eo) : 0);
  endtask

  // observe the grant for the current slot before advancing, for R9/R10
  task automatic observe_and_step(input bit en_v);
    en = en_v;
    #1;
    if (en_v) begin
      for (int c = 0; c < N; c++) begin
        if (grant[c]) begin
          win_cnt[c]++;
          if (last_hit[c] >= 0)
            check("R10", en_steps - last_hit[c], period_of(c));
          last_hit[c] = en_steps;
        end
      end
      en_steps++;
    end
    step(en_v);
  endtask

  task automatic check_window();
    for (int c = 0; c < N; c++) begin
      check("R9", win_cnt[c], 64 / period_of(c));
      win_cnt[c] = 0;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    int en_done;
    seed = 32'h1234_5a5a;
    void'($urandom(seed));
    for (int c = 0; c < N; c++) begin win_cnt[c] = 0; last_hit[c] = -1; end

    // R1: reset state
    rst = 1; en = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", int'(owner), 0);
    check("R1", int'(grant), 1);
    en = 0; #1;
    check("R3", int'(grant), 0);
    rst = 0;
    slot_m = 0;

    // Directed: two full enabled frames, window counts (R9, R10)
    for (int w = 0; w < 2; w++) begin
      for (int i = 0; i < 64; i++) observe_and_step(1'b1);
      check_window();
    end

    // Directed corner: enable drops exactly on slot 63 (wrap collision)
    while (slot_m != 63) step(1'b1);
    step(1'b0); step(1'b0);
    check("R3", int'(owner), 15);
    step(1'b1);
    check("R2", int'(owner), 0);

    // Random enable gaps; windows counted over enabled clocks only
    for (int c = 0; c < N; c++) begin win_cnt[c] = 0; last_hit[c] = -1; end
    while (slot_m != 0) step(1'b1);
    for (int w = 0; w < 6; w++) begin
      en_done = 0;
      while (en_done < 64) begin
        if (($urandom % 4) == 0) begin
          observe_and_step(1'b0);
        end else begin
          observe_and_step(1'b1);
          en_done++;
        end
      end
      check_window();
    end

    // Reset mid-frame returns to slot 0 (R1)
    repeat (5) step(1'b1);
    rst = 1; en = 1;
    @(posedge clk); @(negedge clk);
    rst = 0; slot_m = 0;
    check("R1", int'(owner), 0);
    check("R1", int'(grant), 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule